// File: doc/BRIEF.md
# 8-bit Expansion Bus Cycle Sequencer

This block sits between a host port and a slow expansion bus whose devices are all 8 bits wide. The host posts one request of up to four bytes. The request carries a byte-enable mask, a read or write flag, and a flag that selects I/O space or memory space. The sequencer runs one 8-bit bus cycle for each enabled byte lane, lowest lane first. The address of lane i is the request address plus i. On a write it drives the matching byte of the write word. On a read it places each returned byte into its lane of the result word. The block then raises a one-cycle done pulse, and the result word is valid in that same cycle.

The bus clock comes from the host clock through a divider. The divisor is taken from a strap input while reset is held. All bus timing advances on bus-clock ticks. Each bus cycle has one setup clock followed by a command phase, and ready and zero-wait are sampled in the command phase. A ready input that is low stretches the command phase. An active zero-wait input ends it early, but ready has priority. A programmable recovery count puts extra idle bus clocks between consecutive I/O cycles.

Top module: `ebus_byte_sequencer`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, `done` is 0, `bus_doe` is 0 and all four strobes are high (inactive).
- R2: `bus_clk` has a period of D host clocks. D is latched from `div_sel` during reset: a value of 0 or 1 gives the default D = 4, and any value from 2 to 7 gives D equal to that value.
- R3: Bus cycles run only for lanes whose `req_be` bit is set, in ascending lane order. The address of lane i is `req_addr + i`.
- R4: In a write cycle, `bus_dout` carries byte i of `req_wdata` (bits 8i+7..8i) and `bus_doe` is 1 while the strobe is low. In a read cycle, `bus_doe` is 0.
- R5: For a read, byte i of `rdata` holds the `bus_din` value sampled in lane i's cycle. Lanes that are not enabled read as 0.
- R6: Exactly one strobe is low during a bus cycle. The mapping is I/O read → `bus_ior_n`, I/O write → `bus_iow_n`, memory read → `bus_memr_n`, memory write → `bus_memw_n`, and no strobe is low at any other time.
- R7: With ready high and zero-wait inactive, the strobe stays low for CMD_CLKS (default 4) bus clocks.
- R8: Each command-phase tick that samples `bus_ready` low adds one bus clock to the strobe.
- R9: A command-phase tick that samples `bus_ready` high and `bus_zws_n` low ends the strobe. With no waits, the strobe then lasts 1 bus clock.
- R10: When `bus_ready` is low and `bus_zws_n` is low at the same tick, the wait is taken. W such ticks followed by zero-wait give a strobe of W+1 bus clocks.
- R11: Between two consecutive byte cycles of an I/O request, the strobes stay high for `rec_ticks` + 2 bus clocks. For a memory request the gap is 2 bus clocks.
- R12: `done` is a single-cycle pulse that comes after the strobe of the last byte cycle has returned high. A request whose mask is all zero produces `done` with no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | SEL_W (3) | Divisor strap, latched during reset |
| rec_ticks | input | REC_W (4) | Recovery bus clocks added after each I/O byte cycle |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W (16) | Address of lane 0 |
| req_be | input | LANES (4) | Byte-lane enables |
| req_wdata | input | 8*LANES (32) | Write word |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8*LANES (32) | Assembled read word |
| bus_clk | output | 1 | Divided bus clock |
| bus_addr | output | ADDR_W (16) | Byte address on the bus |
| bus_dout | output | 8 | Write byte |
| bus_doe | output | 1 | Write-data drive enable |
| bus_din | input | 8 | Read byte |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_iow_n | output | 1 | I/O write strobe, active low |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_ready | input | 1 | Ready; low requests wait states |
| bus_zws_n | input | 1 | Zero-wait request, active low |

## Verification
Ready and zero-wait are driven low at the same time. A design that gave zero-wait priority would cut those cycles short, and the measured strobe width would come out too low. Sparse and unaligned masks such as 0101 and 0110 check that lanes are skipped and that addresses follow base plus lane. A design that packed the bytes, or used the lane count for the address, would produce the wrong bus address and put read data in the wrong lanes. The gap between strobes is measured for I/O and for memory requests, under two recovery settings and two divisors. This catches a recovery count applied to memory cycles or off by one tick. An all-zero mask checks that done still arrives and that no bus cycle is started.

// File: rtl/ebus_pkg.sv
// Shared types for the expansion bus byte sequencer.
package ebus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a host request
        ST_SCAN  = 2'd1,   // choose next lane or finish
        ST_SETUP = 2'd2,   // address valid, strobe inactive
        ST_CMD   = 2'd3    // strobe active, ready/zero-wait sampled
    } seq_state_t;
endpackage

// File: rtl/ebus_clkdiv.sv
// Bus clock generator.
// Divides the host clock by a divisor latched from a strap while reset is low.
// Strap values below 2 select DEFAULT_DIV. Produces a registered bus clock and
// a one-host-cycle tick in the cycle before each bus clock rising edge.
// Assumes DEFAULT_DIV >= 2.
module ebus_clkdiv #(
    parameter int SEL_W       = 3,
    parameter int DEFAULT_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             bus_clk,
    output logic             tick
);
    localparam int DEF_W = $clog2(DEFAULT_DIV + 1);
    localparam int CNT_W = (SEL_W > DEF_W) ? SEL_W : DEF_W;

    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] div_dec;

    // Decode the strap into a divisor value.
    always_comb div_dec = (div_sel < SEL_W'(2)) ? CNT_W'(DEFAULT_DIV) : CNT_W'(div_sel);

    assign tick = (cnt_q == div_q - CNT_W'(1));

    // Next count value, wrapping at the divisor.
    always_comb cnt_nxt = tick ? '0 : cnt_q + CNT_W'(1);

    // Latch the strap during reset, hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= div_dec;
    end

    // Host-cycle counter and registered bus clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bus_clk <= 1'b1;
        end else begin
            cnt_q   <= cnt_nxt;
            bus_clk <= (cnt_nxt < (div_q >> 1));
        end
    end

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("tick on two adjacent host cycles");
endmodule

// File: rtl/ebus_rec_timer.sv
// Recovery timer.
// Loaded at the end of each I/O byte cycle, counts down one per bus tick.
// A load wins over a decrement. busy stays high until the count reaches zero.
module ebus_rec_timer #(
    parameter int REC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [REC_W-1:0] load_val,
    output logic             busy
);
    logic [REC_W-1:0] cnt_q;

    // Load or count down the remaining recovery bus clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (tick && cnt_q != '0)  cnt_q <= cnt_q - REC_W'(1);
    end

    assign busy = (cnt_q != '0);

    assert_rec_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && busy) |=> (cnt_q == $past(cnt_q) - REC_W'(1)))
        else $error("recovery count did not step down");
endmodule

// File: rtl/ebus_lane_pick.sv
// Lowest-set-lane finder.
// Returns the index of the lowest set bit of the remaining lane mask, so that
// lanes are issued in ascending address order. Purely combinational.
module ebus_lane_pick #(
    parameter int LANES = 4,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0]  mask,
    output logic              any,
    output logic [LANE_W-1:0] idx
);
    // Scan from the top so the lowest set lane is the one that remains.
    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask[i]) idx = LANE_W'(i);
        end
        any = |mask;
    end
endmodule

// File: rtl/ebus_cycle_fsm.sv
// Byte cycle sequencer.
// Takes a host request, walks its enabled lanes lowest first, and runs one
// setup clock plus a command phase per lane on the bus. Ready/zero-wait are
// sampled at each bus tick in the command phase, and ready has priority.
// Read bytes are assembled into rdata. Recovery gating applies to I/O only.
// Assumes tick comes from the bus clock generator.
module ebus_cycle_fsm
    import ebus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LANES    = 4,
    parameter int CMD_CLKS = 4,
    localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int DATA_W  = 8 * LANES,
    localparam int CMDC_W  = (CMD_CLKS > 1) ? $clog2(CMD_CLKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rec_busy,
    output logic              rec_load,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_dout,
    output logic              bus_doe,
    input  logic [7:0]        bus_din,
    output logic              bus_ior_n,
    output logic              bus_iow_n,
    output logic              bus_memr_n,
    output logic              bus_memw_n,
    input  logic              bus_ready,
    input  logic              bus_zws_n
);
    seq_state_t        state;
    logic [LANES-1:0]  mask_q;
    logic              write_q;
    logic              io_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANE_W-1:0] lane_q;
    logic [CMDC_W-1:0] cmd_cnt;
    logic              pick_any;
    logic [LANE_W-1:0] pick_idx;
    logic              cmd_end;
    logic [LANES-1:0]  below_lane;

    ebus_lane_pick #(.LANES(LANES)) lane_pick_i (
        .mask (mask_q),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    // The command phase ends when ready is seen high and either zero-wait is active or the count is used up.
    always_comb cmd_end = bus_ready && (!bus_zws_n || cmd_cnt == CMDC_W'(CMD_CLKS - 1));

    assign rec_load  = (state == ST_CMD) && tick && cmd_end && io_q;
    assign req_ready = (state == ST_IDLE);

    // Main sequencing: accept, pick lane, setup, command, assemble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mask_q     <= '0;
            write_q    <= 1'b0;
            io_q       <= 1'b0;
            base_q     <= '0;
            wdata_q    <= '0;
            lane_q     <= '0;
            cmd_cnt    <= '0;
            done       <= 1'b0;
            rdata      <= '0;
            bus_addr   <= '0;
            bus_dout   <= '0;
            bus_doe    <= 1'b0;
            bus_ior_n  <= 1'b1;
            bus_iow_n  <= 1'b1;
            bus_memr_n <= 1'b1;
            bus_memw_n <= 1'b1;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    mask_q  <= req_be;
                    write_q <= req_write;
                    io_q    <= req_io;
                    base_q  <= req_addr;
                    wdata_q <= req_wdata;
                    rdata   <= '0;
                    state   <= ST_SCAN;
                end
                ST_SCAN: if (!pick_any) begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end else if (tick && !(io_q && rec_busy)) begin
                    lane_q   <= pick_idx;
                    bus_addr <= base_q + ADDR_W'(pick_idx);
                    bus_dout <= wdata_q[{pick_idx, 3'b000} +: 8];
                    bus_doe  <= write_q;
                    state    <= ST_SETUP;
                end
                ST_SETUP: if (tick) begin
                    cmd_cnt    <= '0;
                    bus_ior_n  <= !(io_q && !write_q);
                    bus_iow_n  <= !(io_q && write_q);
                    bus_memr_n <= !(!io_q && !write_q);
                    bus_memw_n <= !(!io_q && write_q);
                    state      <= ST_CMD;
                end
                ST_CMD: if (tick) begin
                    if (cmd_end) begin
                        bus_ior_n      <= 1'b1;
                        bus_iow_n      <= 1'b1;
                        bus_memr_n     <= 1'b1;
                        bus_memw_n     <= 1'b1;
                        bus_doe        <= 1'b0;
                        mask_q[lane_q] <= 1'b0;
                        if (!write_q) rdata[{lane_q, 3'b000} +: 8] <= bus_din;
                        state          <= ST_SCAN;
                    end else if (bus_ready) begin
                        cmd_cnt <= cmd_cnt + CMDC_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Mask of the lanes below the one in flight, used by the ordering check.
    always_comb below_lane = (LANES'(1) << lane_q) - LANES'(1);

    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && tick && !bus_ready) |=> (state == ST_CMD))
        else $error("command phase left while ready low");

    assert_ready_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && tick && !bus_ready && !bus_zws_n) |=>
            !(bus_ior_n && bus_iow_n && bus_memr_n && bus_memw_n))
        else $error("zero-wait overrode a wait request");

    assert_zws_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && tick && bus_ready && !bus_zws_n) |=> (state == ST_SCAN))
        else $error("zero-wait did not end the command phase");

    assert_rec_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && io_q && rec_busy && mask_q != '0) |=> (state == ST_SCAN))
        else $error("I/O cycle started during recovery");

    assert_lane_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |-> (mask_q[lane_q] && (mask_q & below_lane) == '0))
        else $error("lane issued out of ascending order");

    assert_done_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_ior_n && bus_iow_n && bus_memr_n && bus_memw_n))
        else $error("done while a strobe is active");
endmodule

// File: rtl/ebus_byte_sequencer.sv
// Top level of the 8-bit expansion bus cycle sequencer.
// Connects the bus clock generator, the recovery timer and the byte-cycle
// sequencer. Assumes the host holds the request fields while req_valid is
// high and req_ready is high.
module ebus_byte_sequencer #(
    parameter int ADDR_W      = 16,
    parameter int LANES       = 4,
    parameter int SEL_W       = 3,
    parameter int DEFAULT_DIV = 4,
    parameter int REC_W       = 4,
    parameter int CMD_CLKS    = 4,
    localparam int DATA_W     = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic [REC_W-1:0]  rec_ticks,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_clk,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_dout,
    output logic              bus_doe,
    input  logic [7:0]        bus_din,
    output logic              bus_ior_n,
    output logic              bus_iow_n,
    output logic              bus_memr_n,
    output logic              bus_memw_n,
    input  logic              bus_ready,
    input  logic              bus_zws_n
);
    logic tick;
    logic rec_busy;
    logic rec_load;

    ebus_clkdiv #(.SEL_W(SEL_W), .DEFAULT_DIV(DEFAULT_DIV)) clkdiv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .bus_clk (bus_clk),
        .tick    (tick)
    );

    ebus_rec_timer #(.REC_W(REC_W)) rec_timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (rec_load),
        .load_val (rec_ticks),
        .busy     (rec_busy)
    );

    ebus_cycle_fsm #(.ADDR_W(ADDR_W), .LANES(LANES), .CMD_CLKS(CMD_CLKS)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rec_busy   (rec_busy),
        .rec_load   (rec_load),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_io     (req_io),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .done       (done),
        .rdata      (rdata),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .bus_doe    (bus_doe),
        .bus_din    (bus_din),
        .bus_ior_n  (bus_ior_n),
        .bus_iow_n  (bus_iow_n),
        .bus_memr_n (bus_memr_n),
        .bus_memw_n (bus_memw_n),
        .bus_ready  (bus_ready),
        .bus_zws_n  (bus_zws_n)
    );

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~bus_ior_n, ~bus_iow_n, ~bus_memr_n, ~bus_memw_n}) <= 1)
        else $error("more than one strobe active");
endmodule

// File: tb/ebus_byte_sequencer_tb_top.sv
// Self-checking bench: vector table walk, then directed reset/divisor/gap cases.
module ebus_byte_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic [3:0]  rec_ticks = 4'd2;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic        bus_clk;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic [7:0]  bus_din;
    logic        bus_ior_n, bus_iow_n, bus_memr_n, bus_memw_n;
    logic        bus_ready = 1'b1;
    logic        bus_zws_n = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ebus_byte_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .rec_ticks(rec_ticks),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .bus_clk(bus_clk), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_memr_n(bus_memr_n),
        .bus_memw_n(bus_memw_n), .bus_ready(bus_ready), .bus_zws_n(bus_zws_n)
    );

    // Device model: read byte is a function of the address.
    assign bus_din = bus_addr[7:0] ^ 8'h5A;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bus monitor state.
    int cur_w = 0;
    int div_exp = 4;
    int nb = 0;
    int lowcnt = 0;
    int highcnt = 0;
    bit prev_strb = 1'b0;
    logic [15:0] log_addr [8];
    logic [7:0]  log_dout [8];
    logic        log_doe  [8];
    logic [3:0]  log_kind [8];
    int          log_len  [8];
    int          log_gap  [8];

    // Record each strobe window and drive ready from the strobe age.
    always @(negedge clk) begin
        bit strb;
        strb = !(bus_ior_n && bus_iow_n && bus_memr_n && bus_memw_n);
        if (strb) begin
            if (!prev_strb) begin
                if (nb < 8) begin
                    log_addr[nb] = bus_addr;
                    log_dout[nb] = bus_dout;
                    log_doe[nb]  = bus_doe;
                    log_kind[nb] = {bus_ior_n, bus_iow_n, bus_memr_n, bus_memw_n};
                    log_gap[nb]  = highcnt;
                end
                lowcnt = 1;
            end else begin
                lowcnt++;
            end
            highcnt = 0;
            bus_ready = !(lowcnt <= cur_w * div_exp);
        end else begin
            if (prev_strb) begin
                if (nb < 8) log_len[nb] = lowcnt;
                nb++;
            end
            highcnt++;
            bus_ready = 1'b1;
        end
        prev_strb = strb;
    end

    typedef struct packed {
        logic        io;
        logic        wr;
        logic [3:0]  be;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [3:0]  waits;
        logic        zws;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 4'hF, 16'h0060, 32'h0000_0000, 4'd0, 1'b0},
        '{1'b1, 1'b1, 4'h5, 16'h0370, 32'h1122_3344, 4'd1, 1'b0},
        '{1'b0, 1'b0, 4'hA, 16'hF004, 32'h0000_0000, 4'd0, 1'b1},
        '{1'b1, 1'b0, 4'h8, 16'h0100, 32'h0000_0000, 4'd2, 1'b1},
        '{1'b0, 1'b1, 4'hF, 16'hE000, 32'hA1B2_C3D4, 4'd0, 1'b0},
        '{1'b1, 1'b1, 4'h6, 16'h02F9, 32'hCAFE_BABE, 4'd0, 1'b1},
        '{1'b1, 1'b0, 4'h3, 16'h03F8, 32'h0000_0000, 4'd3, 1'b0},
        '{1'b0, 1'b0, 4'h1, 16'h1234, 32'h0000_0000, 4'd0, 1'b0}
    };

    // Issue one request and check every byte cycle and the completion.
    task automatic run_req(input vec_t v, input int rec);
        int to;
        int exp_n;
        int j;
        logic [31:0] exp_rd;
        logic [3:0]  exp_kind;
        exp_n = $countones(v.be);
        cur_w = int'(v.waits);
        bus_zws_n = !v.zws;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nb = 0;
        req_io = v.io; req_write = v.wr; req_be = v.be;
        req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        to = 0;
        while (!done && to < 4000) begin
            @(negedge clk);
            to++;
        end
        chk(done === 1'b1, "R12", "done seen", done, 1);
        chk(nb == exp_n, "R12", "byte cycles before done", nb, exp_n);
        exp_rd = '0;
        exp_kind = v.io ? (v.wr ? 4'b1011 : 4'b0111) : (v.wr ? 4'b1110 : 4'b1101);
        j = 0;
        for (int ln = 0; ln < 4; ln++) begin
            if (v.be[ln]) begin
                logic [15:0] a;
                a = v.addr + 16'(ln);
                if (!v.wr) exp_rd[ln*8 +: 8] = a[7:0] ^ 8'h5A;
                if (j < nb && j < 8) begin
                    chk(log_addr[j] == a, "R3", "lane address", log_addr[j], a);
                    chk(log_kind[j] == exp_kind, "R6", "strobe kind", log_kind[j], exp_kind);
                    chk(log_doe[j] == v.wr, "R4", "data drive", log_doe[j], v.wr);
                    if (v.wr)
                        chk(log_dout[j] == v.wdata[ln*8 +: 8], "R4", "write byte",
                            log_dout[j], v.wdata[ln*8 +: 8]);
                    // R7 default / R8 waits / R9 zero-wait / R10 ready wins
                    chk(log_len[j] == div_exp * (cur_w + (v.zws ? 1 : 4)),
                        v.zws ? (cur_w > 0 ? "R10" : "R9") : (cur_w > 0 ? "R8" : "R7"),
                        "strobe width", log_len[j], div_exp * (cur_w + (v.zws ? 1 : 4)));
                    if (j > 0)
                        chk(log_gap[j] == div_exp * ((v.io ? rec : 0) + 2), "R11",
                            "inter-cycle gap", log_gap[j], div_exp * ((v.io ? rec : 0) + 2));
                end
                j++;
            end
        end
        if (!v.wr) chk(rdata == exp_rd, "R5", "assembled read word", rdata, exp_rd);
        @(negedge clk);
        chk(done === 1'b0, "R12", "done single pulse", done, 0);
    endtask

    // Measure bus clock period in host cycles between two rising levels.
    task automatic measure_period(output int p);
        int c;
        logic pv;
        pv = bus_clk;
        c = 0;
        while (!(bus_clk && !pv) && c < 100) begin pv = bus_clk; @(negedge clk); c++; end
        p = 0;
        pv = bus_clk;
        @(negedge clk);
        p = 1;
        while (!(bus_clk && !pv) && p < 100) begin pv = bus_clk; @(negedge clk); p++; end
    endtask

    task automatic apply_reset(input logic [2:0] sel);
        rst_n = 1'b0;
        div_sel = sel;
        repeat (4) @(negedge clk);
        chk(req_ready && !done && !bus_doe && bus_ior_n && bus_iow_n && bus_memr_n && bus_memw_n,
            "R1", "outputs during reset", {req_ready, done, bus_doe}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && bus_ior_n && bus_iow_n && bus_memr_n && bus_memw_n,
            "R1", "outputs after reset", {req_ready, done}, 2'b10);
    endtask

    initial begin
        int p;
        vec_t d;
        apply_reset(3'd0);
        div_exp = 4;
        measure_period(p);
        chk(p == 4, "R2", "default divisor period", p, 4);

        rec_ticks = 4'd2;
        for (int i = 0; i < NVEC; i++) run_req(VECS[i], 2);

        // R12: empty mask completes without a bus cycle.
        d = '{1'b1, 1'b0, 4'h0, 16'h0080, 32'h0, 4'd0, 1'b0};
        run_req(d, 2);

        // R2: strap 3 selects divisor 3; R11 with zero recovery.
        apply_reset(3'd3);
        div_exp = 3;
        measure_period(p);
        chk(p == 3, "R2", "strap divisor 3 period", p, 3);
        rec_ticks = 4'd0;
        d = '{1'b1, 1'b1, 4'h3, 16'h0040, 32'h0000_5566, 4'd0, 1'b0};
        run_req(d, 0);
        rec_ticks = 4'd5;
        d = '{1'b1, 1'b0, 4'hC, 16'h0044, 32'h0, 4'd1, 1'b0};
        run_req(d, 5);

        // R2: strap 1 falls back to the default divisor.
        apply_reset(3'd1);
        div_exp = 4;
        measure_period(p);
        chk(p == 4, "R2", "strap 1 default period", p, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule